// File: doc/BRIEF.md
# Two-Wire Switch Management Read Master

This block is the master side of a two-wire management bus: one serial clock line and one shared data line. It reads one 16-bit register from a switch device, given a 16-bit register address. A host pulses `start` with the address on `addr`. The block then runs one read frame on the bus and returns the register contents on `rdata`, together with a one-cycle `done` strobe.

The serial clock comes from the system clock. Each of its half-periods lasts `HALF_DIV` system clocks, and it rests low while the bus is idle. The shared data line is modelled as three signals: an output value, an output-enable, and a separate input.

A frame goes as follows:
1. The master drives a short start pattern, with no run of leading ones.
2. It shifts out an 8-bit command byte.
3. It sends the address as two bytes, low byte first.
4. It releases the line for one turnaround clock.
5. It samples two data bytes, low byte first.
6. It drives a two-bit stop pattern.
7. It gives one more clock pulse before going idle.

Top module: `swmgmt_rd`

## Requirements
- R1: After reset and between frames, `mdc`, `mdio_oe`, `busy` and `done` are all low.
- R2: The first three rising edges of `mdc` in a frame carry the data bits 1, 0, 1, with `mdio_oe` high. No clock pulse comes before them.
- R3: Rising edges 4 to 11 carry the command byte `RD_CMD` (default 0xA9), most-significant bit first, with `mdio_oe` high.
- R4: Rising edges 12 to 19 carry bits 7..0 of `addr`, and rising edges 20 to 27 carry bits 15..8. Both bytes are sent MSB first, with `mdio_oe` high.
- R5: `mdio_oe` is low at rising edges 28 to 44. Edge 28 is the turnaround and edges 29 to 44 are the data bits.
- R6: The input is sampled at rising edges 29 to 44. Edges 29 to 36 give bits 7..0 of the result and edges 37 to 44 give bits 15..8, each byte MSB first. The 16-bit result appears on `rdata`.
- R7: Rising edges 45 and 46 carry the stop bits 0 then 1, and edge 47 is one extra pulse with the line driven high. `mdio_oe` is high at all three edges. A frame has exactly 47 rising edges.
- R8: Consecutive rising edges of `mdc` within a frame are exactly 2*`HALF_DIV` system clocks apart.
- R9: `busy` rises on the clock after an accepted `start` and stays high until `done`. A `start` seen while `busy` is high is ignored: the frame in flight is unchanged and no second frame follows.
- R10: `done` is high for exactly one system clock at the end of the frame, with `busy` already low. `rdata` holds its value until the next `done`.
- R11: `mdio_o` and `mdio_oe` change only while `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a read (one-cycle pulse) |
| addr | input | 16 | Register address, captured with `start` |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdc | output | 1 | Serial management clock |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Data line drive enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-read strobe |
| rdata | output | 16 | Assembled read value |

## Verification
A bit-slot counter off by one shows up on the bus within one serial clock period. It either misplaces the turnaround, which changes the enable sampled at edges 27 or 28, or it changes the total pulse count of 47. A bad shift register or bad byte order corrupts the captured frame or `rdata` at the end of that same frame. A divider fault breaks the spacing between rising edges from the first pair onward. The device model checks the enable, the value and the edge spacing at every rising edge, so most internal faults are seen within the frame that shows them.

// File: rtl/swmgmt_rd.sv
module swmgmt_rd #(
  parameter int          HALF_DIV = 4,
  parameter logic [7:0]  RD_CMD   = 8'hA9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] addr,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
  localparam logic [5:0] TA   = 6'd27;
  localparam logic [5:0] RD0  = 6'd28;
  localparam logic [5:0] RD1  = 6'd43;
  localparam logic [5:0] ST0  = 6'd44;
  localparam logic [5:0] XTRA = 6'd46;

  logic [DW-1:0] div;
  logic          phase;
  logic [5:0]    slot;
  logic [26:0]   tx;
  logic [15:0]   rx;

  wire tick = (div == DIV_LAST);

  assign mdc     = phase;
  assign mdio_oe = busy && !(slot >= TA && slot < ST0);
  assign mdio_o  = (slot < TA) ? tx[26] : (slot != ST0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= 1'b0;
      div   <= '0;
      slot  <= '0;
      tx    <= '0;
      rx    <= '0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          tx    <= {3'b101, RD_CMD, addr[7:0], addr[15:8]};
          slot  <= '0;
          div   <= '0;
          phase <= 1'b0;
        end
      end else if (tick) begin
        div <= '0;
        if (!phase) begin
          phase <= 1'b1;
          if (slot >= RD0 && slot <= RD1)
            rx <= {rx[14:0], mdio_i};
        end else begin
          phase <= 1'b0;
          if (slot == XTRA) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            rdata <= {rx[7:0], rx[15:8]};
          end else begin
            slot <= slot + 6'd1;
            if (slot < TA)
              tx <= {tx[25:0], 1'b0};
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

  // R1
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
  // R11
  drive_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/test_swmgmt_rd.sv
module test_swmgmt_rd;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic        mdio_i = 1'b0;
  logic        mdc, mdio_o, mdio_oe, busy, done;
  logic [15:0] rdata;

  swmgmt_rd #(.HALF_DIV(H)) i_swmgmt_rd (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .done(done), .rdata(rdata));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  int cyc = 0, edges = 0, last_rise = 0;
  int per_bad = 0, oe_bad = 0, hi_bad = 0, dones = 0;
  logic [26:0] frm;
  logic [1:0]  stp;
  logic        xb;
  logic [15:0] seq;
  logic        pm = 1'b0, po = 1'b0, poe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !pm) begin
      edges++;
      if (edges > 1 && (cyc - last_rise) != 2 * H) per_bad++;
      last_rise = cyc;
      if (edges <= 27) begin
        frm = {frm[25:0], mdio_o};
        if (!mdio_oe) oe_bad++;
      end else if (edges <= 44) begin
        if (mdio_oe) oe_bad++;
      end else begin
        if (!mdio_oe) oe_bad++;
        if (edges == 45) stp[1] = mdio_o;
        if (edges == 46) stp[0] = mdio_o;
        if (edges == 47) xb = mdio_o;
      end
    end
    if (!mdc && pm && edges >= 28 && edges <= 43)
      mdio_i = seq[15 - (edges - 28)];
    if (mdc && pm && (mdio_o != po || mdio_oe != poe)) hi_bad++;
    if (done) dones++;
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    edges = 0; per_bad = 0; oe_bad = 0; hi_bad = 0; dones = 0;
    frm = '0; stp = '0; xb = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_frame(input logic [15:0] a, input logic [15:0] v);
    chk(frm[26:24] == 3'b101, "R2", "start pattern", 32'(frm[26:24]), 32'h5);
    chk(frm[23:16] == 8'hA9, "R3", "command byte", 32'(frm[23:16]), 32'hA9);
    chk(frm[15:0] == {a[7:0], a[15:8]}, "R4", "address bytes",
        32'(frm[15:0]), 32'({a[7:0], a[15:8]}));
    chk(oe_bad == 0, "R5", "enable at rising edges", 32'(oe_bad), 0);
    chk(rdata == v, "R6", "read data", 32'(rdata), 32'(v));
    chk(stp == 2'b01 && xb, "R7", "stop and extra bits", 32'({stp, xb}), 32'h3);
    chk(edges == 47, "R7", "rising edge count", 32'(edges), 47);
    chk(per_bad == 0, "R8", "clock period errors", 32'(per_bad), 0);
    chk(hi_bad == 0, "R11", "changes while clock high", 32'(hi_bad), 0);
    chk(!busy, "R10", "busy low with done", 32'(busy), 0);
  endtask

  task automatic t_reset_state();
    chk(!mdc && !mdio_oe && !busy && !done, "R1", "reset outputs",
        32'({mdc, mdio_oe, busy, done}), 0);
    chk(rdata == 16'h0, "R1", "reset rdata", 32'(rdata), 0);
  endtask

  task automatic t_read(input logic [15:0] a, input logic [15:0] v);
    bit ok;
    clr();
    seq = {v[7:0], v[15:8]};
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0; addr = ~a;
    chk(busy, "R9", "busy after start", 32'(busy), 1);
    wait_done(ok);
    chk(ok, "R10", "done seen", 32'(ok), 1);
    check_frame(a, v);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", 32'(done), 0);
    repeat (4) @(negedge clk);
    chk(rdata == v, "R10", "rdata held", 32'(rdata), 32'(v));
    chk(!mdc && !mdio_oe && !busy, "R1", "idle after frame",
        32'({mdc, mdio_oe, busy}), 0);
  endtask

  task automatic t_ignore_start(input logic [15:0] a, input logic [15:0] v);
    bit ok;
    clr();
    seq = {v[7:0], v[15:8]};
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; addr = ~a;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(ok);
    chk(ok, "R9", "done seen", 32'(ok), 1);
    chk(frm[15:0] == {a[7:0], a[15:8]}, "R9", "address unchanged",
        32'(frm[15:0]), 32'({a[7:0], a[15:8]}));
    chk(rdata == v, "R9", "data of first frame", 32'(rdata), 32'(v));
    repeat (20) @(negedge clk);
    chk(!busy && dones == 1, "R9", "no second frame",
        32'({busy, 8'(dones)}), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read(16'h1234, 16'hBEEF);
    t_read(16'h0000, 16'hFFFF);
    t_read(16'hFFFF, 16'h0000);
    t_read(16'h00A5, 16'h5A3C);
    t_ignore_start(16'hC381, 16'h8001);
    t_read(16'h7E01, 16'h0180);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule